// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Filtering

This block is the receive half of an asynchronous serial port. It takes the raw line and a strobe running at a fixed multiple of the baud rate, and recovers frames built from a start bit, eight data bits sent least significant bit first, an optional ninth bit and a stop bit. Each bit is decided by a three-sample majority vote around the middle of the bit. A start bit that is no longer low at that point is dropped as line noise.

A multiprocessor enable turns on hardware address filtering, so a node only raises its receive flag for frames meant for it. Two registers control the filter: a slave address and a mask. A frame matches as unicast when it equals the address in every bit where the mask is 1. It matches as broadcast when it is 1 in every bit that is 1 in (address OR mask). Both registers are zero after reset. In that state every frame matches, so the filter is transparent.

A stop bit sampled low sets a sticky framing-error flag. This happens in every mode, and the flag holds until it is cleared.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, the receive flag, the framing-error flag, the received byte and the ninth-bit output are all 0.
- R2: In 8-bit mode with filtering off, a frame with a valid stop bit sets the receive flag and loads the byte (first bit received into bit 0). The ninth-bit output takes the stop bit value, 1.
- R3: In 9-bit mode with filtering off, every frame with a valid stop bit is accepted, whatever its ninth bit. The ninth-bit output shows the received ninth bit.
- R4: In 9-bit mode with filtering on, a frame whose ninth bit is 0 is ignored. The receive flag, byte and ninth-bit output keep their values.
- R5: With filtering on, a frame equal to the slave address in every bit where the mask is 1 is accepted.
- R6: With filtering on, a frame that has a 1 in every bit where (address OR mask) is 1 is accepted as broadcast.
- R7: With filtering on, a frame that matches neither pattern is ignored.
- R8: With address and mask both zero, filtering accepts every address frame.
- R9: In 8-bit mode with filtering on, a frame is accepted only if it matches and its stop bit is valid.
- R10: A stop bit sampled as 0 sets the framing-error flag in every mode, and that frame never sets the receive flag.
- R11: The framing-error flag stays set through later valid frames until the error-clear input is pulsed. The receive flag stays set until the flag-clear input is pulsed. A new acceptance in the same cycle as a clear wins.
- R12: A low pulse on the line that is high again at mid start bit starts no frame and changes no output.
- R13: A single-strobe-wide low glitch inside a data bit of value 1 is outvoted, and the byte is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling strobe, OVERSAMPLE per bit |
| nine_bit_i | input | 1 | 1 selects 9-bit frames, 0 selects 8-bit frames |
| mp_en_i | input | 1 | 1 enables address filtering |
| slave_addr_i | input | DATA_W | Slave address |
| addr_mask_i | input | DATA_W | Address mask, 1 marks a compared bit |
| rxf_clr_i | input | 1 | One-cycle clear of the receive flag |
| fe_clr_i | input | 1 | One-cycle clear of the framing-error flag |
| data_o | output | DATA_W | Last accepted byte |
| bit9_o | output | 1 | Ninth bit (9-bit mode) or stop bit (8-bit mode) of the last accepted frame |
| rxf_o | output | 1 | Receive flag |
| fe_o | output | 1 | Sticky framing-error flag |

## Verification
A wrong bit counter or a vote taken at the wrong point shows up at the ports within one frame, either as a shifted or corrupted byte or as a false framing error. A bad comparison in the filter shows up on the first address frame that should be dropped or kept: the receive flag comes out the wrong way one frame time after the start edge. Each frame is checked against a behavioural model. Between frames the outputs are compared on every clock, so any spurious change to a flag or to the byte is caught in the cycle it happens.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_NINTH,
      ST_STOP
   } rx_state_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("uart_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              tick_i,
   input  logic              nine_bit_i,
   output logic              done_o,
   output logic              stop_ok_o,
   output logic [DATA_W-1:0] data_o,
   output logic              b9_o
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] S_A  = CNT_W'(OVERSAMPLE/2 - 1);
   localparam logic [CNT_W-1:0] S_B  = CNT_W'(OVERSAMPLE/2);
   localparam logic [CNT_W-1:0] S_C  = CNT_W'(OVERSAMPLE/2 + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
   localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(DATA_W - 1);

   if (OVERSAMPLE < 8 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
      $error("uart_rx_frame: OVERSAMPLE must be a power of two, 8 or more");
   end

   rx_state_e         st;
   logic [CNT_W-1:0]  tcnt;
   logic [BIT_W-1:0]  bitn;
   logic [1:0]        smp;
   logic              vote;

   assign vote = vote3(smp[0], smp[1], rx_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         tcnt      <= '0;
         bitn      <= '0;
         smp       <= '1;
         done_o    <= 1'b0;
         stop_ok_o <= 1'b0;
         data_o    <= '0;
         b9_o      <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            if (st == ST_IDLE) begin
               if (!rx_i) begin
                  st   <= ST_START;
                  tcnt <= '0;
               end
            end else begin
               tcnt <= tcnt + 1'b1;
               if (tcnt == S_A) smp[0] <= rx_i;
               if (tcnt == S_B) smp[1] <= rx_i;
               if (tcnt == S_C) begin
                  case (st)
                     ST_START: if (vote) st <= ST_IDLE;
                     ST_DATA:  data_o <= {vote, data_o[DATA_W-1:1]};
                     ST_NINTH: b9_o <= vote;
                     ST_STOP: begin
                        done_o    <= 1'b1;
                        stop_ok_o <= vote;
                        st        <= ST_IDLE;
                     end
                     default: st <= ST_IDLE;
                  endcase
               end
               if (tcnt == LAST) begin
                  tcnt <= '0;
                  case (st)
                     ST_START: begin
                        st   <= ST_DATA;
                        bitn <= '0;
                     end
                     ST_DATA: begin
                        if (bitn == TOP_BIT) st <= nine_bit_i ? ST_NINTH : ST_STOP;
                        else                 bitn <= bitn + 1'b1;
                     end
                     ST_NINTH: st <= ST_STOP;
                     default:  st <= ST_IDLE;
                  endcase
               end
            end
         end
      end
   end
endmodule

// File: rtl/uart_addr_match.sv
module uart_addr_match #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] frame_i,
   input  logic [DATA_W-1:0] addr_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              hit_o
);
   logic [DATA_W-1:0] uni_ok;
   logic [DATA_W-1:0] bc_ok;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      assign uni_ok[g] = ~mask_i[g] | (frame_i[g] ~^ addr_i[g]);
      assign bc_ok[g]  = ~(addr_i[g] | mask_i[g]) | frame_i[g];
   end

   assign hit_o = (&uni_ok) | (&bc_ok);
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              tick_i,
   input  logic              nine_bit_i,
   input  logic              mp_en_i,
   input  logic [DATA_W-1:0] slave_addr_i,
   input  logic [DATA_W-1:0] addr_mask_i,
   input  logic              rxf_clr_i,
   input  logic              fe_clr_i,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o,
   output logic              rxf_o,
   output logic              fe_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("uart_addr_rx: DATA_W must be at least 2");
   end

   logic              rx_s;
   logic              frm_done;
   logic              frm_stop_ok;
   logic [DATA_W-1:0] frm_data;
   logic              frm_b9;
   logic              addr_hit;
   logic              is_addr;
   logic              accept;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (rx_s)
   );

   uart_rx_frame #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_i       (rx_s),
      .tick_i     (tick_i),
      .nine_bit_i (nine_bit_i),
      .done_o     (frm_done),
      .stop_ok_o  (frm_stop_ok),
      .data_o     (frm_data),
      .b9_o       (frm_b9)
   );

   uart_addr_match #(.DATA_W(DATA_W)) u_match (
      .frame_i (frm_data),
      .addr_i  (slave_addr_i),
      .mask_i  (addr_mask_i),
      .hit_o   (addr_hit)
   );

   assign is_addr = nine_bit_i ? frm_b9 : 1'b1;
   assign accept  = frm_done & frm_stop_ok & (~mp_en_i | (is_addr & addr_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         bit9_o <= 1'b0;
         rxf_o  <= 1'b0;
         fe_o   <= 1'b0;
      end else begin
         if (rxf_clr_i) rxf_o <= 1'b0;
         if (accept) begin
            rxf_o  <= 1'b1;
            data_o <= frm_data;
            bit9_o <= nine_bit_i ? frm_b9 : frm_stop_ok;
         end
         if (fe_clr_i) fe_o <= 1'b0;
         if (frm_done && !frm_stop_ok) fe_o <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              nine_bit_i,
   input logic              mp_en_i,
   input logic [DATA_W-1:0] slave_addr_i,
   input logic [DATA_W-1:0] addr_mask_i,
   input logic              rxf_clr_i,
   input logic              fe_clr_i,
   input logic [DATA_W-1:0] data_o,
   input logic              bit9_o,
   input logic              rxf_o,
   input logic              fe_o
);
   logic [DATA_W-1:0] bc_pat;
   logic              uni_eq;
   logic              bc_eq;

   assign bc_pat = slave_addr_i | addr_mask_i;
   assign uni_eq = ((data_o ^ slave_addr_i) & addr_mask_i) == '0;
   assign bc_eq  = (data_o & bc_pat) == bc_pat;

   AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fe_o && !fe_clr_i |=> fe_o); // R11
   AST_RXF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_o && !rxf_clr_i |=> rxf_o); // R11
   AST_DATA_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_o) |-> rxf_o); // R4
   AST_FE_NOT_WITH_RXF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fe_o) |-> !$rose(rxf_o)); // R10
   AST_NINTH_IS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mp_en_i && nine_bit_i && $rose(rxf_o) |-> bit9_o); // R4
   AST_FILTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      mp_en_i && $rose(rxf_o) |-> (uni_eq || bc_eq)); // R7
   AST_EIGHT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      !nine_bit_i && $rose(rxf_o) |-> bit9_o); // R9
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .nine_bit_i   (nine_bit_i),
   .mp_en_i      (mp_en_i),
   .slave_addr_i (slave_addr_i),
   .addr_mask_i  (addr_mask_i),
   .rxf_clr_i    (rxf_clr_i),
   .fe_clr_i     (fe_clr_i),
   .data_o       (data_o),
   .bit9_o       (bit9_o),
   .rxf_o        (rxf_o),
   .fe_o         (fe_o)
);

// File: tb/tb_uart_addr_rx.sv
module tb_uart_addr_rx;
   localparam int W = 8;
   localparam int CLK_PER_BIT = 64; // 16 strobes, one every 4 clocks

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rx = 1'b1;
   logic         tick = 1'b0;
   logic         nine = 1'b0;
   logic         mp = 1'b0;
   logic [W-1:0] saddr = '0;
   logic [W-1:0] smask = '0;
   logic         rxf_clr = 1'b0;
   logic         fe_clr = 1'b0;
   logic [W-1:0] data;
   logic         bit9;
   logic         rxf;
   logic         fe;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int tdiv = 0;
   bit quiet = 1'b0;
   string cur_req = "R1";

   logic [W-1:0] e_data = '0;
   logic         e_b9 = 1'b0;
   logic         e_rxf = 1'b0;
   logic         e_fe = 1'b0;

   uart_addr_rx #(.DATA_W(W), .OVERSAMPLE(16), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick),
      .nine_bit_i(nine), .mp_en_i(mp), .slave_addr_i(saddr), .addr_mask_i(smask),
      .rxf_clr_i(rxf_clr), .fe_clr_i(fe_clr),
      .data_o(data), .bit9_o(bit9), .rxf_o(rxf), .fe_o(fe)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      tdiv <= (tdiv + 1) % 4;
      tick <= (tdiv == 3);
   end

   task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #3;
      if (quiet && rst_n) begin
         check(cur_req, "rxf", 16'(rxf), 16'(e_rxf));
         check(cur_req, "fe", 16'(fe), 16'(e_fe));
         check(cur_req, "data", 16'(data), 16'(e_data));
         check(cur_req, "bit9", 16'(bit9), 16'(e_b9));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic bit model_match(input logic [W-1:0] f);
      bit uni = 1'b1;
      bit bc = 1'b1;
      for (int i = 0; i < W; i++) begin
         if (smask[i] && (f[i] != saddr[i])) uni = 1'b0;
         if ((saddr[i] || smask[i]) && !f[i]) bc = 1'b0;
      end
      return uni || bc;
   endfunction

   // noise_bit >= 0 puts a one-clock low pulse in the middle of that data bit
   task automatic send(input string req, input logic [W-1:0] b, input logic b9v,
                       input logic stopv, input int noise_bit);
      bit acc;
      cur_req = req;
      @(negedge clk);
      rx = 1'b0;
      repeat (CLK_PER_BIT) @(negedge clk);
      for (int i = 0; i < W; i++) begin
         rx = b[i];
         for (int c = 0; c < CLK_PER_BIT; c++) begin
            @(negedge clk);
            if (i == noise_bit) rx = (c == CLK_PER_BIT/2) ? 1'b0 : b[i];
         end
      end
      if (nine) begin
         rx = b9v;
         repeat (CLK_PER_BIT) @(negedge clk);
      end
      quiet = 1'b0;
      rx = stopv;
      repeat (CLK_PER_BIT) @(negedge clk);
      rx = 1'b1;
      repeat (CLK_PER_BIT) @(negedge clk);
      acc = stopv && (!mp || ((nine ? b9v : 1'b1) && model_match(b)));
      if (acc) begin
         e_rxf  = 1'b1;
         e_data = b;
         e_b9   = nine ? b9v : 1'b1;
      end
      if (!stopv) e_fe = 1'b1;
      quiet = 1'b1;
   endtask

   task automatic clear_rxf(input string req);
      cur_req = req;
      @(negedge clk);
      quiet = 1'b0;
      rxf_clr = 1'b1;
      @(negedge clk);
      rxf_clr = 1'b0;
      e_rxf = 1'b0;
      quiet = 1'b1;
   endtask

   task automatic clear_fe(input string req);
      cur_req = req;
      @(negedge clk);
      quiet = 1'b0;
      fe_clr = 1'b1;
      @(negedge clk);
      fe_clr = 1'b0;
      e_fe = 1'b0;
      quiet = 1'b1;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "reset rxf", 16'(rxf), 16'h0);
      check("R1", "reset fe", 16'(fe), 16'h0);
      check("R1", "reset data", 16'(data), 16'h0);
      check("R1", "reset bit9", 16'(bit9), 16'h0);
      quiet = 1'b1;

      // R2: 8-bit, filter off
      send("R2", 8'hA5, 1'b0, 1'b1, -1);
      check("R2", "8-bit byte", 16'(data), 16'h00A5);
      check("R2", "8-bit flag", 16'(rxf), 16'h1);
      clear_rxf("R11");
      send("R2", 8'h01, 1'b0, 1'b1, -1);
      clear_rxf("R11");

      // R3: 9-bit, filter off, ninth bit 0 still taken
      nine = 1'b1;
      send("R3", 8'h3C, 1'b0, 1'b1, -1);
      check("R3", "ninth bit 0 accepted", 16'(rxf), 16'h1);
      check("R3", "ninth bit value", 16'(bit9), 16'h0);
      clear_rxf("R11");

      // R8 then R4: filter on, transparent registers
      mp = 1'b1;
      send("R8", 8'h77, 1'b1, 1'b1, -1);
      check("R8", "zero regs match", 16'(rxf), 16'h1);
      clear_rxf("R11");
      send("R4", 8'h12, 1'b0, 1'b1, -1);
      check("R4", "data frame ignored", 16'(rxf), 16'h0);
      check("R4", "byte kept", 16'(data), 16'h0077);

      // R5/R6/R7 with address 0xC0, mask 0xFD
      saddr = 8'hC0;
      smask = 8'hFD;
      send("R5", 8'hC2, 1'b1, 1'b1, -1);
      check("R5", "unicast hit", 16'(rxf), 16'h1);
      clear_rxf("R11");
      send("R7", 8'hC1, 1'b1, 1'b1, -1);
      check("R7", "miss ignored", 16'(rxf), 16'h0);
      send("R6", 8'hFF, 1'b1, 1'b1, -1);
      check("R6", "broadcast hit", 16'(rxf), 16'h1);
      clear_rxf("R11");

      // R9/R10/R11 in 8-bit mode with filter on
      nine = 1'b0;
      send("R9", 8'hC0, 1'b0, 1'b1, -1);
      check("R9", "8-bit match", 16'(rxf), 16'h1);
      clear_rxf("R11");
      send("R10", 8'hC0, 1'b0, 1'b0, -1);
      check("R10", "bad stop no flag", 16'(rxf), 16'h0);
      check("R10", "bad stop error", 16'(fe), 16'h1);
      send("R11", 8'h55, 1'b0, 1'b1, -1);
      check("R11", "error sticky", 16'(fe), 16'h1);
      check("R9", "8-bit miss", 16'(rxf), 16'h0);
      clear_fe("R11");
      check("R11", "error cleared", 16'(fe), 16'h0);

      // R10 in 9-bit mode, filter off
      nine = 1'b1;
      mp = 1'b0;
      send("R10", 8'h5A, 1'b1, 1'b0, -1);
      check("R10", "9-bit bad stop error", 16'(fe), 16'h1);
      clear_fe("R11");

      // R12: short start glitch
      nine = 1'b0;
      cur_req = "R12";
      @(negedge clk);
      rx = 1'b0;
      repeat (12) @(negedge clk);
      rx = 1'b1;
      repeat (4 * CLK_PER_BIT) @(negedge clk);
      check("R12", "glitch no flag", 16'(rxf), 16'h0);
      check("R12", "glitch no error", 16'(fe), 16'h0);

      // R13: noise inside a data bit
      send("R13", 8'hFF, 1'b0, 1'b1, 3);
      check("R13", "noise outvoted", 16'(data), 16'h00FF);

      repeat (10) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule